// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the stream of internal column addresses for one read or write burst of a synchronous DRAM. A seven-bit mode word, loaded on a strobe, selects an address ordering (linear increment or low-bit XOR interleave), a burst length (1, 2, 4 or 8 beats, or an open-ended full-page burst), and a CAS latency. The decoded latency is driven out as a clock count so that a downstream read-data pipeline can align itself.

A start pulse supplies an 8-bit starting column. Beginning on the next clock, the block emits one column per cycle with a valid flag. A fixed-length burst marks its final beat. A full-page burst keeps wrapping through all 256 columns until a terminate input stops it. Settings that the memory does not accept raise an error flag, and while that flag is high, start pulses are refused.

Ordering and length are captured at start. A new mode word loaded during a burst therefore only applies to later bursts.

Top module: `sdram_colseq`

## Requirements
- R1: `mode_word` is latched on a clock edge where `mode_load` is high. Its fields are: bit 3 selects the ordering (0 linear, 1 interleave); bits 2:0 select the length (000→1, 001→2, 010→4, 011→8, 111→full page, all other codes reserved); bits 6:4 select the CAS latency. After reset the stored word is 7'b0010000, which gives linear order, length 1 and latency 1.
- R2: `cas_lat` equals 1, 2 or 3 when the latency code is 001, 010 or 011. It is 0 for any reserved latency code (000 or bit 6 set).
- R3: `cfg_error` is high exactly when the stored word has one of these: a reserved latency code, a reserved length code, or interleave order with a length other than 4 or 8.
- R4: A start accepted at a clock edge makes `col_valid` high from the next cycle on, with `col_addr` equal to the start column. One new beat follows each clock.
- R5: In linear order, beat k carries (start + k) mod 256.
- R6: In interleave order, beat k carries the start column with its low bits XORed with k. Bits 1:0 change for length 4 and bits 2:0 for length 8; higher bits keep their start values.
- R7: A fixed-length burst of N beats shows exactly N valid beats. `burst_last` is high only on the Nth beat, and `col_valid` is low in the following cycle unless a new start was accepted.
- R8: A full-page burst continues past 256 beats, wrapping modulo 256, and never asserts `burst_last`.
- R9: `terminate` high at a clock edge during a burst ends it: `col_valid` is low in the next cycle. If a start is accepted at the same edge, the start takes priority.
- R10: A start accepted during an active burst restarts the sequence at beat 0 from the new column, using the ordering and length stored at that moment.
- R11: While `cfg_error` is high, `start` has no effect. An idle block stays idle, and a running burst continues unchanged.
- R12: Loading a new mode word during a burst leaves that burst's ordering, length and remaining beats unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Strobe that stores `mode_word` |
| mode_word | input | 7 | Latency, order and length fields |
| start | input | 1 | Burst start pulse |
| start_col | input | 8 | First column of the burst |
| terminate | input | 1 | Ends the running burst |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| burst_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency in clocks, 0 when reserved |
| cfg_error | output | 1 | Stored mode word is illegal |

## Verification
The bench starts linear bursts near column 255 to expose wrap errors. A design that carried into a ninth bit, or that used interleave for them, would emit wrong columns after the wrap. Interleave bursts start at columns whose upper bits are nonzero, so an XOR that reached too many bits, or an adder used in its place, shows up at once. Full-page bursts run past 256 beats to catch a premature `burst_last` or a counter that saturates. The bench also loads illegal words, restarts mid-burst, terminates and starts at the same edge, and reloads the mode mid-burst. These catch a block that ignores the error gate, lets terminate override start, or applies a new mode word to a burst already in flight.

// File: rtl/colseq_pkg.sv
// Shared types for the burst column sequencer.
// Assumes: the length code table is fixed; widths live in the modules.
package colseq_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Burst settings captured at start.
    typedef struct packed {
        order_e     ord;
        logic       full;      // open-ended burst, stops on terminate only
        logic [2:0] last_idx;  // beat index of the final beat (fixed bursts)
    } burst_cfg_t;

endpackage

// File: rtl/colseq_mode_dec.sv
// Mode register and decoder.
// Holds the programmed mode word and turns it into burst settings, a
// latency count and a legality flag.
// Assumes: field positions are latency [6:4], order [3], length [2:0].
module colseq_mode_dec
    import colseq_pkg::*;
#(
    parameter int          MODE_W     = 7,
    parameter int          LAT_W      = 2,
    parameter logic [6:0]  RESET_MODE = 7'b0010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    output burst_cfg_t        cfg,
    output logic [LAT_W-1:0]  lat_clks,
    output logic              bad_cfg
);

    logic [MODE_W-1:0] mode_q;
    logic [2:0]        lat_code;
    logic [2:0]        len_code;
    logic              len_ok;
    logic              lat_ok;
    logic              order_ok;

    // Store the mode word on its load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_W'(RESET_MODE);
        else if (mode_load)
            mode_q <= mode_word;
    end

    // Decode the length field into a last-beat index or the full-page flag.
    always_comb begin
        len_code     = mode_q[2:0];
        cfg.ord      = order_e'(mode_q[3]);
        cfg.full     = 1'b0;
        cfg.last_idx = 3'd0;
        len_ok       = 1'b1;
        case (len_code)
            3'b000:  cfg.last_idx = 3'd0;
            3'b001:  cfg.last_idx = 3'd1;
            3'b010:  cfg.last_idx = 3'd3;
            3'b011:  cfg.last_idx = 3'd7;
            3'b111:  cfg.full     = 1'b1;
            default: len_ok       = 1'b0;
        endcase
    end

    // Decode latency and combine the legality checks.
    always_comb begin
        lat_code = mode_q[6:4];
        lat_ok   = (lat_code == 3'b001) || (lat_code == 3'b010) || (lat_code == 3'b011);
        lat_clks = lat_ok ? LAT_W'(lat_code) : '0;
        order_ok = (cfg.ord == ORD_LINEAR) || (len_code == 3'b010) || (len_code == 3'b011);
        bad_cfg  = !(lat_ok && len_ok && order_ok);
    end

endmodule

// File: rtl/colseq_beat_ctr.sv
// Burst state: active flag, beat counter, start column and captured settings.
// Assumes: launch is already gated by the legality flag; launch beats
// terminate; the counter wraps modulo 2**COL_W in full-page bursts.
module colseq_beat_ctr
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             terminate,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] base,
    output burst_cfg_t       cfg_q,
    output logic             at_last
);

    // Flag the final beat of a fixed-length burst.
    always_comb begin
        at_last = active && !cfg_q.full && (beat == COL_W'(cfg_q.last_idx));
    end

    // Start, advance, or end the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
            base   <= '0;
            cfg_q  <= '0;
        end else if (launch) begin
            active <= 1'b1;
            beat   <= '0;
            base   <= start_col;
            cfg_q  <= cfg_in;
        end else if (active) begin
            if (terminate || at_last)
                active <= 1'b0;
            else
                beat <= beat + 1'b1;
        end
    end

endmodule

// File: rtl/colseq_addr_map.sv
// Maps start column and beat index to a column address.
// Linear order adds (wraps modulo 2**COL_W). Interleave order XORs the low
// XOR_W bits. Higher bits pass through, since the beat index stays below
// 2**XOR_W in interleave bursts.
module colseq_addr_map
    import colseq_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int XOR_W = 3
) (
    input  order_e           ord,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] sum;

    // Linear-order column, truncated to the column width.
    always_comb sum = base + beat;

    // Per-bit select between sum and XOR or pass-through.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < XOR_W) begin : g_xor
            assign addr[i] = (ord == ORD_XOR) ? (base[i] ^ beat[i]) : sum[i];
        end else begin : g_keep
            assign addr[i] = (ord == ORD_XOR) ? base[i] : sum[i];
        end
    end

endmodule

// File: rtl/sdram_colseq.sv
// Top: SDRAM burst column address sequencer.
// Decodes the mode word and runs one burst at a time, emitting one column
// per clock starting the cycle after an accepted start.
// Assumes: a synchronous active-low reset; start refused while the mode is illegal.
module sdram_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 7,
    parameter int LAT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              terminate,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              burst_last,
    output logic [LAT_W-1:0]  cas_lat,
    output logic              cfg_error
);

    localparam int XOR_W = 3;

    burst_cfg_t       cfg_now;
    burst_cfg_t       cfg_run;
    logic             launch;
    logic             active;
    logic             at_last;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;

    colseq_mode_dec #(.MODE_W(MODE_W), .LAT_W(LAT_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .cfg       (cfg_now),
        .lat_clks  (cas_lat),
        .bad_cfg   (cfg_error)
    );

    // Accept a start only under a legal mode.
    always_comb launch = start && !cfg_error;

    colseq_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .terminate (terminate),
        .start_col (start_col),
        .cfg_in    (cfg_now),
        .active    (active),
        .beat      (beat),
        .base      (base),
        .cfg_q     (cfg_run),
        .at_last   (at_last)
    );

    colseq_addr_map #(.COL_W(COL_W), .XOR_W(XOR_W)) u_map (
        .ord  (cfg_run.ord),
        .base (base),
        .beat (beat),
        .addr (col_addr)
    );

    // Drive the beat flags.
    always_comb begin
        col_valid  = active;
        burst_last = at_last;
    end

endmodule

// File: rtl/colseq_chk.sv
// Port-level properties of the column sequencer, bound into the top.
module colseq_chk #(
    parameter int COL_W = 8,
    parameter int LAT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             terminate,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             burst_last,
    input logic [LAT_W-1:0] cas_lat,
    input logic             cfg_error
);

    // R4
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !cfg_error |=> col_valid && col_addr == $past(start_col));

    // R7
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last |-> col_valid);

    // R7
    ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_last && !start |=> !col_valid);

    // R9
    terminate_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && terminate && !start |=> !col_valid);

    // R11
    refused_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid && start && cfg_error |=> !col_valid);

    // R2
    legal_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_error |-> cas_lat != '0);

    // R5
    beats_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && $past(col_valid) && !$past(start) |-> col_addr != $past(col_addr));

endmodule

bind sdram_colseq colseq_chk #(.COL_W(COL_W), .LAT_W(LAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .terminate  (terminate),
    .col_addr   (col_addr),
    .col_valid  (col_valid),
    .burst_last (burst_last),
    .cas_lat    (cas_lat),
    .cfg_error  (cfg_error)
);

// File: tb/sdram_colseq_test.sv
// Bench: a behavioural reference model updated on each rising edge and
// compared against every output on each falling edge.
module sdram_colseq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_load;
    logic [6:0] mode_word;
    logic       start;
    logic [7:0] start_col;
    logic       terminate;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       burst_last;
    logic [1:0] cas_lat;
    logic       cfg_error;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Reference model state
    logic [6:0] m_mode;
    bit         m_active;
    int         m_base;
    int         m_k;
    int         m_len;   // -1 means full page
    bit         m_ilv;

    always #5 clk = ~clk;

    sdram_colseq uut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .terminate(terminate),
        .col_addr(col_addr), .col_valid(col_valid), .burst_last(burst_last),
        .cas_lat(cas_lat), .cfg_error(cfg_error)
    );

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return -1;
            default: return 0;
        endcase
    endfunction

    function automatic bit err_of(input logic [6:0] w);
        int  l = len_of(w[2:0]);
        int  c = int'(w[6:4]);
        bit  e = 0;
        if (c < 1 || c > 3) e = 1;
        if (l == 0) e = 1;
        if (w[3] && !(l == 4 || l == 8)) e = 1;
        return e;
    endfunction

    function automatic logic [6:0] mw(input int cas, input bit ilv, input int len);
        return {cas[2:0], ilv, len[2:0]};
    endfunction

    // Reference model: advance on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 7'b0010000;
            m_active = 0; m_base = 0; m_k = 0; m_len = 1; m_ilv = 0;
        end else begin
            if (start && !err_of(m_mode)) begin
                m_active = 1; m_base = int'(start_col); m_k = 0;
                m_len = len_of(m_mode[2:0]); m_ilv = m_mode[3];
            end else if (m_active) begin
                if (terminate) m_active = 0;
                else if (m_len > 0 && m_k == m_len - 1) m_active = 0;
                else m_k = (m_k + 1) % 256;
            end
            if (mode_load) m_mode = mode_word;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int c = int'(m_mode[6:4]);
        int e_addr = m_ilv ? (m_base ^ m_k) : ((m_base + m_k) % 256);
        chk("col_valid", int'(col_valid), int'(m_active));
        if (m_active) chk("col_addr", int'(col_addr), e_addr);
        chk("burst_last", int'(burst_last), int'(m_active && m_len > 0 && m_k == m_len - 1));
        chk("cas_lat", int'(cas_lat), (c >= 1 && c <= 3) ? c : 0);
        chk("cfg_error", int'(cfg_error), int'(err_of(m_mode)));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        mode_load = 0; start = 0; terminate = 0;
    endtask

    task automatic load(input logic [6:0] w);
        mode_load = 1; mode_word = w;
        tick();
    endtask

    task automatic go(input logic [7:0] col);
        start = 1; start_col = col;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; mode_load = 0; mode_word = '0; start = 0; start_col = '0; terminate = 0;
        @(negedge clk);
        idle(3);
        rst_n = 1;
        cur_req = "R1";  // reset state: length 1, latency 1, idle
        idle(2);
        go(8'h42); idle(2);

        cur_req = "R5";  // linear length 4 wrapping past 255
        load(mw(2, 0, 2)); go(8'hFE); idle(5);
        cur_req = "R7";  // linear lengths 8 and 2
        load(mw(3, 0, 3)); go(8'hFC); idle(10);
        load(mw(1, 0, 1)); go(8'h10); idle(3);

        cur_req = "R6";  // interleave 8 and 4 with upper bits set
        load(mw(2, 1, 3)); go(8'h35); idle(10);
        load(mw(3, 1, 2)); go(8'hCE); idle(6);

        cur_req = "R2";  // latency codes, legal and reserved
        load(mw(1, 0, 0)); load(mw(2, 0, 0)); load(mw(3, 0, 0));
        load(mw(0, 0, 0)); load(mw(5, 0, 0)); load(mw(7, 0, 3));

        cur_req = "R3";  // illegal pairs and reserved length codes
        load(mw(2, 1, 1)); load(mw(2, 1, 0)); load(mw(2, 1, 7));
        load(mw(2, 0, 4)); load(mw(2, 0, 6));

        cur_req = "R11"; // start refused under an illegal mode
        load(mw(2, 1, 1)); go(8'h20); idle(3);
        load(mw(2, 0, 3)); go(8'h50); idle(2);
        load(mw(0, 0, 3)); go(8'h90); idle(8);

        cur_req = "R8";  // full page past 256 beats
        load(mw(2, 0, 7)); go(8'hF0); idle(300);
        cur_req = "R9";  // terminate ends the burst
        terminate = 1; tick(); idle(3);

        cur_req = "R9";  // terminate and start together: start wins
        go(8'h07); idle(4);
        start = 1; start_col = 8'hA0; terminate = 1; tick(); idle(4);
        terminate = 1; tick(); idle(2);

        cur_req = "R10"; // restart mid-burst with a new column
        load(mw(2, 0, 3)); go(8'h11); idle(3); go(8'h80); idle(10);
        load(mw(2, 1, 3)); go(8'h18); idle(2); go(8'h2B); idle(10);

        cur_req = "R12"; // mode reload mid-burst does not change it
        load(mw(2, 0, 3)); go(8'h60); idle(2);
        load(mw(3, 1, 2)); idle(8);
        go(8'h64); idle(6);

        cur_req = "R4";  // back-to-back single-beat bursts
        load(mw(1, 0, 0)); go(8'h01); go(8'h02); go(8'hFF); idle(3);

        summary();
        $finish;
    end

endmodule